// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host-side operation request and the write/read bus of a parallel NOR flash. It takes an operation code, a target word address, a data word and a word count. It then plays out, one bus cycle at a time, the exact list of command writes the flash needs for that operation. The list includes the two-cycle unlock prefix, the multi-cycle erase scripts and the variable-length buffered-program script. For the identifier and query operations, the block follows the command with plain read cycles and hands each returned word back to the host.

Every bus cycle is offered on `bus_valid` and completes on the clock edge where `bus_ready` is high. The flash port is byte addressed, so word addresses are shifted left by a parameter. Words for a buffered program are not stored in the block. It drives `buf_index` and takes `buf_wdata` from the host at the moment that data cycle is offered. Electrical timing, wait states and completion polling are handled elsewhere.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation codes 0 (identify), 2 (program), 3 (buffered program), 4 (sector erase) and 5 (chip erase) begin with a write of 0xAA to word 0x555 and then a write of 0x55 to word 0x2AA.
- R2: Identify (code 0) writes 0x90 to word 0x555 after the unlock pair. It then issues four read cycles, at words 0x00, 0x01, 0x0E and 0x0F in that order.
- R3: Program (code 2) writes 0xA0 to word 0x555 after the unlock pair. It then writes `req_wdata` to the target word, for four cycles in all.
- R4: Sector erase (code 4) runs six cycles: the unlock pair, 0x80 to 0x555, a second unlock pair, and then 0x30 to the target word.
- R5: Chip erase (code 5) runs the same six cycles as R4, except that the last cycle writes 0x10 to word 0x555.
- R6: Buffered program (code 3) with count N runs N+5 cycles in this order: the unlock pair, 0x25 to the start word, N−1 to the start word, then N data cycles, then 0x29 to the last loaded word. Data cycle i writes `buf_wdata` to start+i while `buf_index` equals i.
- R7: Return-to-read (code 1) is a single write of 0xF0 to the target word. Query (code 6) writes 0x98 to word 0x55 and then reads words 0x10 to 0x13 in ascending order.
- R8: The bus address equals the word address shifted left by ADDR_SHIFT bits. While `bus_ready` is low, the offered cycle's address, direction and data stay unchanged.
- R9: When a read cycle completes, `rd_valid` is high for one cycle in the following clock, and `rd_data` holds the `bus_rdata` value taken at completion.
- R10: `busy` and `bus_valid` rise in the cycle after a request is accepted and stay high until the last cycle completes. A request made while busy is ignored and does not change the running script.
- R11: `done` pulses for exactly one cycle, in the cycle after the last bus cycle of a script completes.
- R12: The following requests are rejected: code 7, and a buffered program whose count is 0 or above BUF_MAX. A rejected request raises `err` for one cycle in the next clock, and it issues no bus cycle and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request, taken when not busy |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Target or start word address |
| req_wdata | input | DW | Data word for single program |
| req_count | input | CW = clog2(BUF_MAX+1) | Word count for buffered program |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse after the last bus cycle |
| err | output | 1 | One-cycle pulse for a rejected request |
| buf_index | output | CW | Index of the buffered word being written |
| buf_wdata | input | DW | Buffered word selected by buf_index |
| bus_valid | output | 1 | Bus cycle offered |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW+ADDR_SHIFT | Byte address of the cycle |
| bus_wdata | output | DW | Write data of the cycle |
| bus_ready | input | 1 | Completes the offered cycle at this edge |
| bus_rdata | input | DW | Read data, taken when a read completes |
| rd_valid | output | 1 | Returned read word is valid |
| rd_data | output | DW | Returned read word |

## Verification
The assertions check four behaviours on every clock:
- The first cycle of every unlocked script is the 0xAA write.
- An offered cycle holds steady and the script never aborts while the bus stalls.
- `done`, `rd_valid` and `err` each appear only after the event that justifies them.

The exact content and order of each script can only be shown by the bench's scenarios. That covers the buffered-program length at a count of one and at the limit, its wrap of the address space, and the device addresses of the read cycles. The bench scenarios also show that a request during a script is refused, and which counts are rejected.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDENT   = 3'd0,
        OP_TO_READ = 3'd1,
        OP_PROG    = 3'd2,
        OP_BUFPROG = 3'd3,
        OP_SECTOR  = 3'd4,
        OP_CHIP    = 3'd5,
        OP_QUERY   = 3'd6,
        OP_INVALID = 3'd7
    } nor_op_e;

    // word addresses of the command cycles
    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [11:0] QRY_ADDR   = 12'h055;
    localparam logic [11:0] QRY_BASE   = 12'h010;

    // command bytes
    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_PROG      = 8'hA0;
    localparam logic [7:0] C_ERASE_PRE = 8'h80;
    localparam logic [7:0] C_SECTOR    = 8'h30;
    localparam logic [7:0] C_CHIP      = 8'h10;
    localparam logic [7:0] C_LOAD      = 8'h25;
    localparam logic [7:0] C_COMMIT    = 8'h29;
    localparam logic [7:0] C_TO_READ   = 8'hF0;
    localparam logic [7:0] C_QUERY     = 8'h98;

endpackage

// File: rtl/nor_addr_shift.sv
module nor_addr_shift #(
    parameter int AW    = 24,
    parameter int SHIFT = 1
) (
    input  logic [AW-1:0]       word_addr,
    output logic [AW+SHIFT-1:0] byte_addr
);
    generate
        if (SHIFT == 0) begin : g_direct
            assign byte_addr = word_addr;
        end else begin : g_shifted
            assign byte_addr = {word_addr, {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/nor_step_gen.sv
module nor_step_gen
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int CW = 6,
    parameter int SW = 6
) (
    input  nor_op_e         op,
    input  logic [SW-1:0]   step,
    input  logic [AW-1:0]   base,
    input  logic [CW-1:0]   count,
    input  logic [DW-1:0]   word,
    input  logic [DW-1:0]   buf_word,
    output logic            cyc_we,
    output logic [AW-1:0]   cyc_addr,
    output logic [DW-1:0]   cyc_data,
    output logic            cyc_last
);
    logic [SW-1:0] load_idx;

    always_comb begin
        cyc_we   = 1'b1;
        cyc_addr = '0;
        cyc_data = '0;
        cyc_last = 1'b0;
        load_idx = step - SW'(4);

        case (op)
            OP_IDENT: begin
                case (step)
                    SW'(0): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(KEY_A); end
                    SW'(1): begin cyc_addr = AW'(KEY_ADDR_B); cyc_data = DW'(KEY_B); end
                    SW'(2): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(C_IDENT); end
                    SW'(3): begin cyc_we = 1'b0; cyc_addr = AW'(12'h000); end
                    SW'(4): begin cyc_we = 1'b0; cyc_addr = AW'(12'h001); end
                    SW'(5): begin cyc_we = 1'b0; cyc_addr = AW'(12'h00E); end
                    default: begin cyc_we = 1'b0; cyc_addr = AW'(12'h00F); cyc_last = 1'b1; end
                endcase
            end
            OP_TO_READ: begin
                cyc_addr = base;
                cyc_data = DW'(C_TO_READ);
                cyc_last = 1'b1;
            end
            OP_PROG: begin
                case (step)
                    SW'(0): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(KEY_A); end
                    SW'(1): begin cyc_addr = AW'(KEY_ADDR_B); cyc_data = DW'(KEY_B); end
                    SW'(2): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(C_PROG); end
                    default: begin cyc_addr = base; cyc_data = word; cyc_last = 1'b1; end
                endcase
            end
            OP_SECTOR, OP_CHIP: begin
                case (step)
                    SW'(0), SW'(3): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(KEY_A); end
                    SW'(1), SW'(4): begin cyc_addr = AW'(KEY_ADDR_B); cyc_data = DW'(KEY_B); end
                    SW'(2): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(C_ERASE_PRE); end
                    default: begin
                        cyc_last = 1'b1;
                        if (op == OP_SECTOR) begin
                            cyc_addr = base;
                            cyc_data = DW'(C_SECTOR);
                        end else begin
                            cyc_addr = AW'(KEY_ADDR_A);
                            cyc_data = DW'(C_CHIP);
                        end
                    end
                endcase
            end
            OP_BUFPROG: begin
                case (step)
                    SW'(0): begin cyc_addr = AW'(KEY_ADDR_A); cyc_data = DW'(KEY_A); end
                    SW'(1): begin cyc_addr = AW'(KEY_ADDR_B); cyc_data = DW'(KEY_B); end
                    SW'(2): begin cyc_addr = base; cyc_data = DW'(C_LOAD); end
                    SW'(3): begin cyc_addr = base; cyc_data = DW'(count) - DW'(1); end
                    default: begin
                        if (load_idx < SW'(count)) begin
                            cyc_addr = base + AW'(load_idx);
                            cyc_data = buf_word;
                        end else begin
                            cyc_addr = base + AW'(count) - AW'(1);
                            cyc_data = DW'(C_COMMIT);
                            cyc_last = 1'b1;
                        end
                    end
                endcase
            end
            OP_QUERY: begin
                if (step == SW'(0)) begin
                    cyc_addr = AW'(QRY_ADDR);
                    cyc_data = DW'(C_QUERY);
                end else begin
                    cyc_we   = 1'b0;
                    cyc_addr = AW'(QRY_BASE) + AW'(step) - AW'(1);
                    cyc_last = (step == SW'(4));
                end
            end
            default: cyc_last = 1'b1;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 24,
    parameter int DW         = 16,
    parameter int ADDR_SHIFT = 1,
    parameter int BUF_MAX    = 32,
    localparam int CW        = $clog2(BUF_MAX + 1),
    localparam int SW        = $clog2(BUF_MAX + 6)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    input  logic [CW-1:0]            req_count,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [CW-1:0]            buf_index,
    input  logic [DW-1:0]            buf_wdata,
    output logic                     bus_valid,
    output logic                     bus_we,
    output logic [AW+ADDR_SHIFT-1:0] bus_addr,
    output logic [DW-1:0]            bus_wdata,
    input  logic                     bus_ready,
    input  logic [DW-1:0]            bus_rdata,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data
);
    typedef struct packed {
        logic          busy;
        nor_op_e       op;
        logic [AW-1:0] addr;
        logic [CW-1:0] count;
        logic [DW-1:0] word;
        logic [SW-1:0] step;
        logic          done;
        logic          err;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          cyc_we;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;
    logic          cyc_last;
    logic          req_bad;
    nor_op_e       req_kind;

    nor_step_gen #(.AW(AW), .DW(DW), .CW(CW), .SW(SW)) u_step (
        .op       (st_q.op),
        .step     (st_q.step),
        .base     (st_q.addr),
        .count    (st_q.count),
        .word     (st_q.word),
        .buf_word (buf_wdata),
        .cyc_we   (cyc_we),
        .cyc_addr (cyc_addr),
        .cyc_data (cyc_data),
        .cyc_last (cyc_last)
    );

    nor_addr_shift #(.AW(AW), .SHIFT(ADDR_SHIFT)) u_shift (
        .word_addr (cyc_addr),
        .byte_addr (bus_addr)
    );

    assign req_kind = nor_op_e'(req_op);
    assign req_bad  = (req_kind == OP_INVALID) ||
                      ((req_kind == OP_BUFPROG) &&
                       ((req_count == '0) || (req_count > CW'(BUF_MAX))));

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.err      = 1'b0;
        st_d.rd_valid = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (req_bad) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy  = 1'b1;
                    st_d.op    = req_kind;
                    st_d.addr  = req_addr;
                    st_d.count = req_count;
                    st_d.word  = req_wdata;
                    st_d.step  = '0;
                end
            end
        end else if (bus_ready) begin
            if (!cyc_we) begin
                st_d.rd_valid = 1'b1;
                st_d.rd_data  = bus_rdata;
            end
            if (cyc_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign bus_valid = st_q.busy;
    assign bus_we    = cyc_we;
    assign bus_wdata = cyc_data;
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign buf_index = (st_q.op == OP_BUFPROG && st_q.step >= SW'(4))
                       ? CW'(st_q.step - SW'(4)) : '0;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW         = 24,
    parameter int DW         = 16,
    parameter int ADDR_SHIFT = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               req_op,
    input logic                     busy,
    input logic                     done,
    input logic                     err,
    input logic                     bus_valid,
    input logic                     bus_we,
    input logic [AW+ADDR_SHIFT-1:0] bus_addr,
    input logic [DW-1:0]            bus_wdata,
    input logic                     bus_ready,
    input logic                     rd_valid
);
    localparam logic [AW+ADDR_SHIFT-1:0] KEY_BYTE_A =
        (AW+ADDR_SHIFT)'(12'h555) << ADDR_SHIFT;

    // R1: an unlocked script opens with the 0xAA key write
    a_r1_unlock_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && ($past(req_op) inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5})
        |-> bus_we && bus_addr == KEY_BYTE_A && bus_wdata == DW'(8'hAA));

    // R8: a stalled cycle is held unchanged
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

    // R10: a running script is never dropped while the bus stalls
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ready |=> busy);

    // R11: done follows a completed cycle and leaves the bus idle
    a_r11_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !bus_valid && $past(bus_valid && bus_ready));

    // R9: a returned word follows a completed read cycle
    a_r9_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && bus_ready && !bus_we));

    // R12: a rejection issues nothing
    a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !bus_valid && !done);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .AW(AW), .DW(DW), .ADDR_SHIFT(ADDR_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .rd_valid  (rd_valid)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
    localparam int AW = 24, DW = 16, SH = 1, BMAX = 32, CW = 6, BAW = AW + SH;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [2:0]     req_op = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [CW-1:0]  req_count = '0;
    logic           busy, done, err, bus_valid, bus_we, rd_valid;
    logic [CW-1:0]  buf_index;
    logic [DW-1:0]  buf_wdata, bus_wdata, bus_rdata, rd_data;
    logic [BAW-1:0] bus_addr;
    logic           bus_ready = 1'b0;

    nor_cmd_seq #(.AW(AW), .DW(DW), .ADDR_SHIFT(SH), .BUF_MAX(BMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
        .busy(busy), .done(done), .err(err), .buf_index(buf_index),
        .buf_wdata(buf_wdata), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // flash model: read data is a function of the byte address
    assign bus_rdata = bus_addr[15:0] ^ 16'h3C00;
    // host buffer: word i is 0xB000 ^ i
    assign buf_wdata = 16'hB000 ^ DW'(buf_index);

    int checks = 0, fails = 0, cyc = 0, stall_mode = 0, tick = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected bus cycles
    bit             q_we[$];
    logic [BAW-1:0] q_addr[$];
    logic [DW-1:0]  q_data[$];
    bit             q_last[$];
    string          q_tag[$];

    task automatic push(input bit we, input logic [AW-1:0] waddr,
                        input logic [DW-1:0] data, input bit last, input string tag);
        q_we.push_back(we);
        q_addr.push_back(BAW'(waddr) << SH);   // R8 shift
        q_data.push_back(data);
        q_last.push_back(last);
        q_tag.push_back(tag);
    endtask

    task automatic build(input int op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int n);
        if (op == 0 || op == 2 || op == 3 || op == 4 || op == 5) begin
            push(1, 24'h555, 16'hAA, 0, "R1");
            push(1, 24'h2AA, 16'h55, 0, "R1");
        end
        case (op)
            0: begin
                push(1, 24'h555, 16'h90, 0, "R2");
                push(0, 24'h000, 0, 0, "R2");
                push(0, 24'h001, 0, 0, "R2");
                push(0, 24'h00E, 0, 0, "R2");
                push(0, 24'h00F, 0, 1, "R2");
            end
            1: push(1, a, 16'hF0, 1, "R7");
            2: begin
                push(1, 24'h555, 16'hA0, 0, "R3");
                push(1, a, d, 1, "R3");
            end
            3: begin
                push(1, a, 16'h25, 0, "R6");
                push(1, a, DW'(n - 1), 0, "R6");
                for (int i = 0; i < n; i++)
                    push(1, a + AW'(i), 16'hB000 ^ DW'(i), 0, "R6");
                push(1, a + AW'(n - 1), 16'h29, 1, "R6");
            end
            4, 5: begin
                push(1, 24'h555, 16'h80, 0, op == 4 ? "R4" : "R5");
                push(1, 24'h555, 16'hAA, 0, op == 4 ? "R4" : "R5");
                push(1, 24'h2AA, 16'h55, 0, op == 4 ? "R4" : "R5");
                if (op == 4) push(1, a, 16'h30, 1, "R4");
                else         push(1, 24'h555, 16'h10, 1, "R5");
            end
            6: begin
                push(1, 24'h055, 16'h98, 0, "R7");
                for (int i = 0; i < 4; i++)
                    push(0, 24'h010 + AW'(i), 0, i == 3, "R7");
            end
            default: ;
        endcase
    endtask

    // cycle-by-cycle comparison and bus slave
    bit            exp_done = 0, exp_rdv = 0;
    logic [DW-1:0] exp_rd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit nready;
            chk(done === exp_done, "R11", "done", done, exp_done);
            chk(rd_valid === exp_rdv, "R9", "rd_valid", rd_valid, exp_rdv);
            if (exp_rdv) chk(rd_data === exp_rd, "R9", "rd_data", rd_data, exp_rd);
            exp_done = 0;
            exp_rdv  = 0;
            tick++;
            nready = (stall_mode == 0) ? 1'b1 : ((tick % 3) != 0);
            if (bus_valid) begin
                if (q_we.size() == 0) begin
                    chk(0, "R10", "cycle with no script", bus_addr, 0);
                end else begin
                    chk(bus_we === q_we[0], q_tag[0], "direction", bus_we, q_we[0]);
                    chk(bus_addr === q_addr[0], {q_tag[0], " R8"}, "address", bus_addr, q_addr[0]);
                    if (q_we[0]) chk(bus_wdata === q_data[0], q_tag[0], "data", bus_wdata, q_data[0]);
                    if (nready) begin
                        if (!q_we[0]) begin
                            exp_rdv = 1;
                            exp_rd  = q_addr[0][15:0] ^ 16'h3C00;
                        end
                        exp_done = q_last[0];
                        void'(q_we.pop_front());
                        void'(q_addr.pop_front());
                        void'(q_data.pop_front());
                        void'(q_last.pop_front());
                        void'(q_tag.pop_front());
                    end
                end
            end
            bus_ready = nready;
        end
    end

    task automatic do_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int n, input bit inject);
        int g;
        @(negedge clk);
        build(op, a, d, n);
        req_op = 3'(op); req_addr = a; req_wdata = d; req_count = CW'(n);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10", "busy after accept", busy, 1);
        chk(err === 1'b0, "R12", "no error on valid request", err, 0);
        if (inject) begin
            @(negedge clk);
            req_op = 3'd5; req_addr = 24'h777777; req_valid = 1'b1;  // R10 refused
            @(negedge clk);
            req_valid = 1'b0;
        end
        g = 0;
        while (!done && g < 2000) begin
            @(negedge clk);
            g++;
        end
        chk(done === 1'b1, "R11", "done reached", done, 1);
        chk(busy === 1'b0, "R10", "busy clear at done", busy, 0);
        chk(q_we.size() == 0, "R10", "script fully issued", q_we.size(), 0);
        @(negedge clk);
        chk(done === 1'b0, "R11", "done single cycle", done, 0);
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(bus_valid === 1'b0, "R10", "refused request started nothing", bus_valid, 0);
            end
        end
    endtask

    task automatic do_bad(input int op, input int n);
        @(negedge clk);
        req_op = 3'(op); req_count = CW'(n); req_addr = 24'h000100;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err === 1'b1, "R12", "err pulse", err, 1);
        chk(busy === 1'b0, "R12", "busy stays low", busy, 0);
        chk(bus_valid === 1'b0, "R12", "no bus cycle", bus_valid, 0);
        @(negedge clk);
        chk(err === 1'b0, "R12", "err single cycle", err, 0);
        chk(bus_valid === 1'b0, "R12", "still no bus cycle", bus_valid, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 60000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R10", "reset busy", busy, 0);
        chk(bus_valid === 1'b0, "R10", "reset bus_valid", bus_valid, 0);
        chk(done === 1'b0, "R11", "reset done", done, 0);
        chk(err === 1'b0, "R12", "reset err", err, 0);

        stall_mode = 0;
        do_op(0, 24'h0, 16'h0, 0, 0);             // R2
        do_op(1, 24'h001234, 16'h0, 0, 0);        // R7
        do_op(2, 24'h00ABCD, 16'h1357, 0, 0);     // R3
        do_op(3, 24'h000100, 16'h0, 1, 0);        // R6 single word
        do_op(3, 24'hFFFFF0, 16'h0, BMAX, 0);     // R6 limit, wraps
        do_op(4, 24'h040000, 16'h0, 0, 0);        // R4
        do_op(5, 24'h0, 16'h0, 0, 0);             // R5
        do_op(6, 24'h0, 16'h0, 0, 0);             // R7 query

        stall_mode = 1;                           // R8 holds under stalls
        do_op(0, 24'h0, 16'h0, 0, 0);
        do_op(2, 24'h3FFFFF, 16'hFFFF, 0, 0);
        do_op(3, 24'h002000, 16'h0, 7, 0);
        do_op(6, 24'h0, 16'h0, 0, 0);
        do_op(3, 24'h000400, 16'h0, 3, 1);        // R10 refusal mid-script
        stall_mode = 0;

        do_bad(3, 0);                             // R12 zero count
        do_bad(3, BMAX + 1);                      // R12 above limit
        do_bad(7, 1);                             // R12 invalid code

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule